// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver

This block turns an asynchronous serial line into whole characters. It checks for a low level on the line at every tick of an oversampling clock enable. Half a bit time later it checks the line again. A low that has already gone high is thrown away. A low that is still there is taken as a start bit. From then on, every following bit is sampled at its centre.

A character has 7 or 8 data bits, sent least significant bit first. After the data come an optional parity bit and then an optional multiprocessor flag bit. Only the first stop bit is checked. In the cycle after the stop bit's centre sample, the character and its error flags are offered to a downstream FIFO for one cycle. A break is a framing error with all data bits zero. It is delivered like any other character, and after it the receiver waits for the line to go high before it looks for a new start bit.

Top module: `async_rx_shifter`

## Requirements
- R1: After reset, `outValid` and `rxOverrun` are low, and they stay low while the line stays high.
- R2: A low level is accepted as a start bit only if the line is still low OVERSAMPLE/2 ticks after the tick that first saw it. A shorter low produces no character, and a following valid character is received correctly.
- R3: Data bits are sampled every OVERSAMPLE ticks after the start check, least significant bit first. `cfgEightBit`=1 selects 8 data bits and `cfgEightBit`=0 selects 7. In 7-bit mode `outData[7]` is 0.
- R4: With `cfgParityOn`=1, one parity bit follows the last data bit. `cfgParityOdd`=0 selects even parity and 1 selects odd parity. `outParityErr` is 1 exactly when the received parity does not match. With parity off, `outParityErr` is 0.
- R5: With `cfgMpOn`=1, one multiprocessor bit follows the parity bit (or the last data bit when parity is off) and is reported on `outMpBit`. With `cfgMpOn`=0, `outMpBit` is 0.
- R6: Only the first stop bit is checked. `outFrameErr` is 1 when it is sampled low.
- R7: `outBreak` is 1 when the stop bit is low and all data bits are zero, and `outFrameErr` is then also 1. After a break, no further character is produced until the line has been seen high.
- R8: Each character raises `outValid` for exactly one clock cycle. That cycle falls inside the stop bit, one clock after the stop bit's centre sample. The FIFO takes the character when `outReady` is high in that cycle.
- R9: If `outReady` is low in the `outValid` cycle, `rxOverrun` is high in that same cycle. The character is dropped and is not offered again.
- R10: While `rxEnable` is low, no character is produced, and `outValid` is low in the cycle after any cycle with `rxEnable` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxEnable | input | 1 | Receiver enable; low forces the receiver idle |
| sampleTick | input | 1 | Oversampling clock enable, OVERSAMPLE ticks per bit |
| serIn | input | 1 | Serial line, idles high |
| cfgEightBit | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfgParityOn | input | 1 | Parity bit present after the data |
| cfgParityOdd | input | 1 | 1: odd parity, 0: even parity |
| cfgMpOn | input | 1 | Multiprocessor bit present before the stop bit |
| outReady | input | 1 | FIFO has a free slot |
| outValid | output | 1 | Character offered, one-cycle pulse |
| outData | output | 8 | Received character |
| outParityErr | output | 1 | Parity mismatch |
| outFrameErr | output | 1 | Stop bit sampled low |
| outBreak | output | 1 | Break detected |
| outMpBit | output | 1 | Received multiprocessor bit |
| rxOverrun | output | 1 | Character offered with no free slot |

## Verification
The bench builds the block with the default OVERSAMPLE of 16 and pulses `sampleTick` once every four clocks, so one bit lasts 64 clocks. This is short enough to send many full frames in every format and still leaves room for the half-bit start check and the centre sampling. With this spacing, a 12-clock glitch ends before the 8-tick start check, and the one-cycle `outValid` pulse can be placed by cycle count inside the stop bit. A low held for 30 bit times shows that the receiver stays blocked after a break.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;
  localparam int DATA_MAX = 8;
  localparam int IDX_W = $clog2(DATA_MAX);
  localparam int FRAME_W = $clog2(DATA_MAX + 3);

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_BITS, ST_STOP, ST_HOLD
  } rxState_t;

  typedef struct packed {
    logic             clear;
    logic             takeData;
    logic [IDX_W-1:0] dataIdx;
    logic             takePar;
    logic             takeMp;
    logic             takeStop;
  } rxStrobe_t;
endpackage

// File: rtl/async_rx_ctrl.sv
module async_rx_ctrl
  import async_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      rxEnable,
  input  logic      sampleTick,
  input  logic      lineBit,
  input  logic      cfgEightBit,
  input  logic      cfgParityOn,
  input  logic      cfgMpOn,
  input  logic      breakNow,
  output rxStrobe_t strobe
);
  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam int HALF = OVERSAMPLE / 2;

  rxState_t state;
  logic [CNT_W-1:0] tickCnt;
  logic [FRAME_W-1:0] bitIdx;
  logic [FRAME_W-1:0] dataLen;
  logic [FRAME_W-1:0] frameLen;
  logic halfPoint;
  logic bitCentre;

  assign dataLen = cfgEightBit ? FRAME_W'(DATA_MAX) : FRAME_W'(DATA_MAX - 1);
  assign frameLen = dataLen + FRAME_W'(cfgParityOn) + FRAME_W'(cfgMpOn);
  assign halfPoint = sampleTick && (tickCnt == CNT_W'(HALF - 1));
  assign bitCentre = sampleTick && (tickCnt == CNT_W'(OVERSAMPLE - 1));

  always_comb begin
    strobe = '0;
    strobe.dataIdx = bitIdx[IDX_W-1:0];
    if (rxEnable) begin
      case (state)
        ST_START: strobe.clear = halfPoint && !lineBit;
        ST_BITS: begin
          if (bitCentre) begin
            if (bitIdx < dataLen) strobe.takeData = 1'b1;
            else if (cfgParityOn && bitIdx == dataLen) strobe.takePar = 1'b1;
            else strobe.takeMp = 1'b1;
          end
        end
        ST_STOP: strobe.takeStop = bitCentre;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      tickCnt <= '0;
      bitIdx <= '0;
    end else if (!rxEnable) begin
      state <= ST_IDLE;
      tickCnt <= '0;
      bitIdx <= '0;
    end else if (sampleTick) begin
      case (state)
        ST_IDLE: begin
          tickCnt <= '0;
          if (!lineBit) state <= ST_START;
        end
        ST_START: begin
          if (halfPoint) begin
            tickCnt <= '0;
            bitIdx <= '0;
            state <= lineBit ? ST_IDLE : ST_BITS;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_BITS: begin
          if (bitCentre) begin
            tickCnt <= '0;
            if (bitIdx == frameLen - FRAME_W'(1)) state <= ST_STOP;
            else bitIdx <= bitIdx + 1'b1;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (bitCentre) begin
            tickCnt <= '0;
            state <= breakNow ? ST_HOLD : ST_IDLE;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_HOLD: if (lineBit) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/async_rx_dpath.sv
module async_rx_dpath
  import async_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                serIn,
  input  logic                cfgParityOn,
  input  logic                cfgParityOdd,
  input  logic                cfgMpOn,
  input  rxStrobe_t           strobe,
  output logic                lineBit,
  output logic                breakNow,
  output logic                outValid,
  output logic [DATA_MAX-1:0] outData,
  output logic                outParityErr,
  output logic                outFrameErr,
  output logic                outBreak,
  output logic                outMpBit
);
  logic [1:0] syncReg;
  logic [DATA_MAX-1:0] dataReg;
  logic parBit;
  logic mpBit;

  assign lineBit = syncReg[1];
  assign breakNow = !lineBit && (dataReg == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncReg <= 2'b11;
      dataReg <= '0;
      parBit <= 1'b0;
      mpBit <= 1'b0;
      outValid <= 1'b0;
      outData <= '0;
      outParityErr <= 1'b0;
      outFrameErr <= 1'b0;
      outBreak <= 1'b0;
      outMpBit <= 1'b0;
    end else begin
      syncReg <= {syncReg[0], serIn};
      if (strobe.clear) begin
        dataReg <= '0;
        parBit <= 1'b0;
        mpBit <= 1'b0;
      end
      if (strobe.takeData) dataReg[strobe.dataIdx] <= lineBit;
      if (strobe.takePar) parBit <= lineBit;
      if (strobe.takeMp) mpBit <= lineBit;
      outValid <= strobe.takeStop;
      if (strobe.takeStop) begin
        outData <= dataReg;
        outFrameErr <= !lineBit;
        outBreak <= breakNow;
        outParityErr <= cfgParityOn && ((^dataReg ^ parBit) != cfgParityOdd);
        outMpBit <= cfgMpOn && mpBit;
      end
    end
  end
endmodule

// File: rtl/async_rx_shifter.sv
module async_rx_shifter
  import async_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxEnable,
  input  logic       sampleTick,
  input  logic       serIn,
  input  logic       cfgEightBit,
  input  logic       cfgParityOn,
  input  logic       cfgParityOdd,
  input  logic       cfgMpOn,
  input  logic       outReady,
  output logic       outValid,
  output logic [7:0] outData,
  output logic       outParityErr,
  output logic       outFrameErr,
  output logic       outBreak,
  output logic       outMpBit,
  output logic       rxOverrun
);
  rxStrobe_t strobe;
  logic lineBit;
  logic breakNow;

  async_rx_ctrl #(.OVERSAMPLE(OVERSAMPLE)) ctrl (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .sampleTick(sampleTick),
    .lineBit(lineBit), .cfgEightBit(cfgEightBit), .cfgParityOn(cfgParityOn),
    .cfgMpOn(cfgMpOn), .breakNow(breakNow), .strobe(strobe)
  );

  async_rx_dpath dpath (
    .clk(clk), .rstN(rstN), .serIn(serIn), .cfgParityOn(cfgParityOn),
    .cfgParityOdd(cfgParityOdd), .cfgMpOn(cfgMpOn), .strobe(strobe),
    .lineBit(lineBit), .breakNow(breakNow), .outValid(outValid),
    .outData(outData), .outParityErr(outParityErr), .outFrameErr(outFrameErr),
    .outBreak(outBreak), .outMpBit(outMpBit)
  );

  assign rxOverrun = outValid && !outReady;
endmodule

// File: rtl/async_rx_chk.sv
module async_rx_chk (
  input logic       clk,
  input logic       rstN,
  input logic       rxEnable,
  input logic       cfgEightBit,
  input logic       cfgParityOn,
  input logic       outValid,
  input logic [7:0] outData,
  input logic       outParityErr,
  input logic       outFrameErr,
  input logic       outBreak
);
  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  // R7
  break_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outBreak) |-> (outFrameErr && outData == 8'h00));

  // R3
  short_char_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !cfgEightBit) |-> !outData[7]);

  // R4
  parity_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !cfgParityOn) |-> !outParityErr);

  // R10
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> !outValid);
endmodule

bind async_rx_shifter async_rx_chk chk (
  .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .cfgEightBit(cfgEightBit),
  .cfgParityOn(cfgParityOn), .outValid(outValid), .outData(outData),
  .outParityErr(outParityErr), .outFrameErr(outFrameErr), .outBreak(outBreak)
);

// File: tb/tb_async_rx_shifter.sv
module tb_async_rx_shifter;
  localparam int BIT_CLKS = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxEnable = 1'b1;
  logic sampleTick = 1'b0;
  logic serIn = 1'b1;
  logic cfgEightBit = 1'b1;
  logic cfgParityOn = 1'b0;
  logic cfgParityOdd = 1'b0;
  logic cfgMpOn = 1'b0;
  logic outReady = 1'b1;
  logic outValid;
  logic [7:0] outData;
  logic outParityErr, outFrameErr, outBreak, outMpBit, rxOverrun;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int nValid = 0;
  int validCyc = 0;
  int stopStart = 0;
  logic [7:0] gotData;
  logic gotPe, gotFe, gotBrk, gotMp, gotOvr;
  bit done = 0;

  async_rx_shifter dut (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .sampleTick(sampleTick),
    .serIn(serIn), .cfgEightBit(cfgEightBit), .cfgParityOn(cfgParityOn),
    .cfgParityOdd(cfgParityOdd), .cfgMpOn(cfgMpOn), .outReady(outReady),
    .outValid(outValid), .outData(outData), .outParityErr(outParityErr),
    .outFrameErr(outFrameErr), .outBreak(outBreak), .outMpBit(outMpBit),
    .rxOverrun(rxOverrun)
  );

  always #5 clk = ~clk;

  initial begin
    int div = 0;
    forever begin
      @(negedge clk);
      sampleTick = (div == 0);
      div = (div + 1) % 4;
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (outValid) begin
        nValid++;
        validCyc = cyc;
        gotData = outData;
        gotPe = outParityErr;
        gotFe = outFrameErr;
        gotBrk = outBreak;
        gotMp = outMpBit;
        gotOvr = rxOverrun;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic holdBits(input logic v, input int n);
    serIn = v;
    repeat (n * BIT_CLKS) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] d, input bit withPar, input logic parVal,
                           input bit withMp, input logic mpVal, input logic stopVal);
    holdBits(1'b0, 1);
    for (int i = 0; i < (cfgEightBit ? 8 : 7); i++) holdBits(d[i], 1);
    if (withPar) holdBits(parVal, 1);
    if (withMp) holdBits(mpVal, 1);
    stopStart = cyc;
    holdBits(stopVal, 1);
    holdBits(1'b1, 2);
  endtask

  task automatic expectChar(input string tag, input int base, input logic [7:0] d,
                            input logic pe, input logic fe, input logic brk,
                            input logic mp, input logic ovr);
    chk({tag, " count"}, nValid - base, 1);
    chk({tag, " data"}, gotData, d);
    chk({tag, " parityErr"}, gotPe, pe);
    chk({tag, " frameErr"}, gotFe, fe);
    chk({tag, " break"}, gotBrk, brk);
    chk({tag, " mp"}, gotMp, mp);
    chk({tag, " overrun"}, gotOvr, ovr);
    // R8 hand-off inside the stop bit
    chk("R8 valid within stop bit", int'(validCyc > stopStart && validCyc < stopStart + BIT_CLKS), 1);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    chk("R1 valid after reset", outValid, 0);
    chk("R1 overrun after reset", rxOverrun, 0);
    rstN = 1'b1;
    repeat (200) @(negedge clk);
    chk("R1 no char on idle line", nValid, 0);
  endtask

  task automatic testEightBit();
    int base = nValid;
    sendFrame(8'hA5, 0, 0, 0, 0, 1);
    expectChar("R3 8bit A5", base, 8'hA5, 0, 0, 0, 0, 0);
    base = nValid;
    sendFrame(8'h3C, 0, 0, 0, 0, 1);
    expectChar("R6 8bit 3C good stop", base, 8'h3C, 0, 0, 0, 0, 0);
  endtask

  task automatic testSevenBit();
    int base = nValid;
    cfgEightBit = 1'b0;
    sendFrame(8'h5A, 0, 0, 0, 0, 1);
    expectChar("R3 7bit 5A", base, 8'h5A, 0, 0, 0, 0, 0);
    cfgEightBit = 1'b1;
  endtask

  task automatic testParity();
    int base;
    logic [7:0] d = 8'h53;
    cfgEightBit = 1'b0;
    cfgParityOn = 1'b1;
    cfgParityOdd = 1'b0;
    base = nValid;
    sendFrame(d, 1, ^d[6:0], 0, 0, 1);
    expectChar("R4 7bit even good", base, d, 0, 0, 0, 0, 0);
    base = nValid;
    sendFrame(d, 1, ~^d[6:0], 0, 0, 1);
    expectChar("R4 7bit even bad", base, d, 1, 0, 0, 0, 0);
    cfgEightBit = 1'b1;
    cfgParityOdd = 1'b1;
    d = 8'hC4;
    base = nValid;
    sendFrame(d, 1, ~^d, 0, 0, 1);
    expectChar("R4 8bit odd good", base, d, 0, 0, 0, 0, 0);
    base = nValid;
    sendFrame(d, 1, ^d, 0, 0, 1);
    expectChar("R4 8bit odd bad", base, d, 1, 0, 0, 0, 0);
    cfgParityOn = 1'b0;
    cfgParityOdd = 1'b0;
  endtask

  task automatic testMp();
    int base = nValid;
    cfgMpOn = 1'b1;
    sendFrame(8'h81, 0, 0, 1, 1, 1);
    expectChar("R5 mp set", base, 8'h81, 0, 0, 0, 1, 0);
    cfgParityOn = 1'b1;
    base = nValid;
    sendFrame(8'h07, 1, 1'b1, 1, 0, 1);
    expectChar("R5 parity then mp", base, 8'h07, 0, 0, 0, 0, 0);
    cfgParityOn = 1'b0;
    cfgMpOn = 1'b0;
  endtask

  task automatic testFraming();
    int base = nValid;
    sendFrame(8'h55, 0, 0, 0, 0, 0);
    expectChar("R6 stop low", base, 8'h55, 0, 1, 0, 0, 0);
  endtask

  task automatic testFalseStart();
    int base = nValid;
    serIn = 1'b0;
    repeat (12) @(negedge clk);
    serIn = 1'b1;
    repeat (3 * BIT_CLKS) @(negedge clk);
    chk("R2 glitch ignored", nValid - base, 0);
    base = nValid;
    sendFrame(8'h96, 0, 0, 0, 0, 1);
    expectChar("R2 frame after glitch", base, 8'h96, 0, 0, 0, 0, 0);
  endtask

  task automatic testBreak();
    int base = nValid;
    holdBits(1'b0, 9);
    stopStart = cyc;
    holdBits(1'b0, 21);
    chk("R7 one char while held low", nValid - base, 1);
    chk("R7 break flag", gotBrk, 1);
    chk("R7 frame err with break", gotFe, 1);
    chk("R7 break data", gotData, 0);
    chk("R8 break valid within stop bit", int'(validCyc > stopStart && validCyc < stopStart + BIT_CLKS), 1);
    holdBits(1'b1, 2);
    base = nValid;
    sendFrame(8'h24, 0, 0, 0, 0, 1);
    expectChar("R7 char after release", base, 8'h24, 0, 0, 0, 0, 0);
  endtask

  task automatic testOverrun();
    int base = nValid;
    outReady = 1'b0;
    sendFrame(8'hE1, 0, 0, 0, 0, 1);
    expectChar("R9 no slot", base, 8'hE1, 0, 0, 0, 0, 1);
    outReady = 1'b1;
    repeat (4 * BIT_CLKS) @(negedge clk);
    chk("R9 dropped char not reoffered", nValid - base, 1);
    base = nValid;
    sendFrame(8'h1E, 0, 0, 0, 0, 1);
    expectChar("R9 slot free again", base, 8'h1E, 0, 0, 0, 0, 0);
  endtask

  task automatic testDisabled();
    int base = nValid;
    rxEnable = 1'b0;
    sendFrame(8'h33, 0, 0, 0, 0, 1);
    chk("R10 disabled no char", nValid - base, 0);
    rxEnable = 1'b1;
    repeat (BIT_CLKS) @(negedge clk);
    base = nValid;
    sendFrame(8'hCC, 0, 0, 0, 0, 1);
    expectChar("R10 char after enable", base, 8'hCC, 0, 0, 0, 0, 0);
  endtask

  initial begin
    testReset();
    testEightBit();
    testSevenBit();
    testParity();
    testMp();
    testFraming();
    testFalseStart();
    testBreak();
    testOverrun();
    testDisabled();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      repeat (200000) @(posedge clk);
    join_any
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule